// File: doc/BRIEF.md
# Gshare Branch Direction Predictor with Selectable History Length

This block predicts whether a conditional branch will be taken. It holds a table of two-bit saturating counters. The table index is formed from the branch word address, XORed with a masked copy of an eight-bit global record of recent branch outcomes. A four-bit control input sets how many of those history bits take part in the hash. The enable bit selects all eight. Otherwise a three-bit count selects the most recent N bits. When all four control bits are zero, the table is indexed by address alone.

A lookup presents the branch word address every cycle, and the taken prediction appears one clock later. Resolution is reported separately. The caller gives the branch word address, the actual outcome, and the history value that was current when that branch was looked up. The update therefore reaches the same counter that produced the prediction, even if the history has shifted since then. The current history is exposed as an output so that the caller can keep it with each in-flight branch.

Top module: `gshare_predictor`

## Requirements
- R1: Synchronous active-high reset sets every counter to weakly not-taken (binary 01), clears the history to zero, and drives the prediction output to 0.
- R2: One clock after a lookup address is presented, `lk_taken` equals bit 1 (the MSB) of the counter that the lookup index selects.
- R3: The index is the 9-bit word address (PC bits 10:2) XORed with the selected history bits. History bit i lands on index bit i, and index bit 8 is never hashed.
- R4: When control bit 3 is 1, all eight history bits are hashed, whatever bits 2:0 hold.
- R5: When control bit 3 is 0 and bits 2:0 hold N, only history bits N-1..0 are hashed. Bit 0 is the most recent outcome, and the older bits are masked to zero.
- R6: When the control value is 0, the index equals the word address, independent of the history.
- R7: A valid resolve increments the selected counter on taken and decrements it on not-taken. The counter saturates at 00 and 11.
- R8: The resolve index is computed from `rs_hist`, not from the current history, and uses the current control value.
- R9: A valid resolve shifts the outcome into history bit 0, and the older bits move up by one. The oldest bit is dropped.
- R10: When a lookup and a resolve select the same counter in one cycle, the prediction reflects the counter value from before the update.
- R11: When `rs_valid` is 0, neither the counters nor the history change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hist_ctrl | input | 4 | Bit 3: use all history bits; bits 2:0: number of recent history bits used |
| lk_word | input | 9 | Lookup branch word address (PC bits 10:2) |
| lk_taken | output | 1 | Registered prediction, 1 = taken |
| ghist | output | 8 | Current global history, bit 0 most recent |
| rs_valid | input | 1 | Resolve strobe |
| rs_word | input | 9 | Resolved branch word address (PC bits 10:2) |
| rs_taken | input | 1 | Actual outcome, 1 = taken |
| rs_hist | input | 8 | History value captured at lookup time for this branch |

## Verification
A lookup and a counter update can occur in the same cycle and select the same counter. In that case the prediction must show the old count. The bench provokes this in directed sequences that look up and resolve one address repeatedly, stepping its counter through both saturation limits. It also provokes it at random by drawing lookup and resolve addresses from a small shared pool with varying control values and stale `rs_hist` values. A reference table and history in the bench compute each prediction from the state before that cycle's update. The update is applied only after that, so any forwarding of the new count is reported.

// File: rtl/gsh_pkg.sv
package gsh_pkg;
  typedef logic [1:0] ctr_t;
  localparam ctr_t CTR_MIN   = 2'b00;
  localparam ctr_t CTR_WEAKN = 2'b01;
  localparam ctr_t CTR_MAX   = 2'b11;
endpackage

// File: rtl/gsh_index_hash.sv
module gsh_index_hash #(
  parameter int HIST_W = 8,
  parameter int IDX_W  = 9,
  parameter int CNT_W  = 3
) (
  input  logic [IDX_W-1:0]  word,
  input  logic [HIST_W-1:0] hist,
  input  logic [CNT_W:0]    ctrl,
  output logic [IDX_W-1:0]  idx
);
  localparam int PAD_W = IDX_W - HIST_W;

  logic [HIST_W-1:0] mask;

  // Mask bit i is kept when all-bits is set or the count exceeds i.
  for (genvar i = 0; i < HIST_W; i++) begin : g_mask
    localparam logic [CNT_W:0] POS = (CNT_W+1)'(i);
    assign mask[i] = ctrl[CNT_W] | ({1'b0, ctrl[CNT_W-1:0]} > POS);
  end

  if (PAD_W > 0) begin : g_pad
    assign idx = word ^ {{PAD_W{1'b0}}, hist & mask};
  end else begin : g_nopad
    assign idx = word ^ IDX_W'(hist & mask);
  end
endmodule

// File: rtl/gsh_hist_reg.sv
module gsh_hist_reg #(
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              outcome,
  output logic [HIST_W-1:0] hist
);
  always_ff @(posedge clk) begin
    if (rst) hist <= '0;
    else if (shift_en) hist <= {hist[HIST_W-2:0], outcome};
  end

  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> hist == {$past(hist[HIST_W-2:0]), $past(outcome)}); // R9
  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(hist)); // R11
endmodule

// File: rtl/gsh_ctr_table.sv
module gsh_ctr_table
  import gsh_pkg::*;
#(
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_taken,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_t mem [DEPTH];
  ctr_t wr_old, wr_new;
  logic rd_old;

  assign wr_old = mem[wr_idx];
  assign rd_old = mem[rd_idx][1];

  always_comb begin
    wr_new = wr_old;
    if (wr_taken && wr_old != CTR_MAX) wr_new = wr_old + 2'd1;
    else if (!wr_taken && wr_old != CTR_MIN) wr_new = wr_old - 2'd1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_taken <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_WEAKN;
    end else begin
      rd_taken <= mem[rd_idx][1];
      if (wr_en) mem[wr_idx] <= wr_new;
    end
  end

  AST_CTR_INC: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_taken && wr_old != CTR_MAX)
      |=> mem[$past(wr_idx)] == $past(wr_old) + 2'd1); // R7
  AST_CTR_DEC: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_taken && wr_old != CTR_MIN)
      |=> mem[$past(wr_idx)] == $past(wr_old) - 2'd1); // R7
  AST_CTR_SAT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_taken && wr_old == CTR_MAX) |=> mem[$past(wr_idx)] == CTR_MAX); // R7
  AST_RD_OLD: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> rd_taken == $past(rd_old)); // R10
endmodule

// File: rtl/gshare_predictor.sv
module gshare_predictor #(
  parameter int HIST_W = 8,
  parameter int IDX_W  = 9,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W:0]    hist_ctrl,
  input  logic [IDX_W-1:0]  lk_word,
  output logic              lk_taken,
  output logic [HIST_W-1:0] ghist,
  input  logic              rs_valid,
  input  logic [IDX_W-1:0]  rs_word,
  input  logic              rs_taken,
  input  logic [HIST_W-1:0] rs_hist
);
  logic [IDX_W-1:0] lk_idx, rs_idx;

  gsh_index_hash #(.HIST_W(HIST_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_lk_hash (
    .word(lk_word), .hist(ghist), .ctrl(hist_ctrl), .idx(lk_idx));

  gsh_index_hash #(.HIST_W(HIST_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_rs_hash (
    .word(rs_word), .hist(rs_hist), .ctrl(hist_ctrl), .idx(rs_idx));

  gsh_ctr_table #(.IDX_W(IDX_W)) u_table (
    .clk(clk), .rst(rst),
    .rd_idx(lk_idx), .rd_taken(lk_taken),
    .wr_en(rs_valid), .wr_idx(rs_idx), .wr_taken(rs_taken));

  gsh_hist_reg #(.HIST_W(HIST_W)) u_hist (
    .clk(clk), .rst(rst), .shift_en(rs_valid), .outcome(rs_taken), .hist(ghist));

  AST_PC_ONLY: assert property (@(posedge clk) disable iff (rst)
    (hist_ctrl == '0) |-> (lk_idx == lk_word && rs_idx == rs_word)); // R6
endmodule

// File: tb/sim_gshare_predictor.sv
module sim_gshare_predictor;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 512;

  logic clk = 1'b0;
  logic rst;
  logic [3:0] hist_ctrl;
  logic [8:0] lk_word, rs_word;
  logic rs_valid, rs_taken;
  logic [7:0] rs_hist;
  logic lk_taken;
  logic [7:0] ghist;

  int runs = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [1:0] model [DEPTH];
  logic [7:0] mhist;

  always #(CLK_PERIOD/2) clk = ~clk;

  gshare_predictor u0 (
    .clk(clk), .rst(rst), .hist_ctrl(hist_ctrl), .lk_word(lk_word),
    .lk_taken(lk_taken), .ghist(ghist), .rs_valid(rs_valid),
    .rs_word(rs_word), .rs_taken(rs_taken), .rs_hist(rs_hist));

  function automatic logic [8:0] ref_idx(logic [8:0] w, logic [7:0] h, logic [3:0] c);
    logic [8:0] r;
    r = w;
    for (int i = 0; i < 8; i++)
      if (c[3] || i < int'(c[2:0])) r[i] = r[i] ^ h[i];
    return r;
  endfunction

  function automatic logic [1:0] sat_step(logic [1:0] v, logic t);
    if (t) return (v == 2'b11) ? v : v + 2'd1;
    return (v == 2'b00) ? v : v - 2'd1;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic [8:0] lw, logic [8:0] rw, logic [3:0] c,
                      logic v, logic t, logic [7:0] rh);
    logic exp_pred;
    logic [8:0] ri;
    lk_word = lw; rs_word = rw; hist_ctrl = c;
    rs_valid = v; rs_taken = t; rs_hist = rh;
    exp_pred = model[ref_idx(lw, mhist, c)][1];
    if (v) begin
      ri = ref_idx(rw, rh, c);
      model[ri] = sat_step(model[ri], t);
      mhist = {mhist[6:0], t};
    end
    @(posedge clk);
    @(negedge clk);
    check({tag, " prediction"}, {7'd0, lk_taken}, {7'd0, exp_pred});
    check({tag, " history"}, ghist, mhist);
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", runs, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) model[i] = 2'b01;
    mhist = 8'h00;
    rst = 1'b1; hist_ctrl = 4'h0; lk_word = '0; rs_word = '0;
    rs_valid = 1'b0; rs_taken = 1'b0; rs_hist = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset prediction", {7'd0, lk_taken}, 8'h00);
    check("R1 reset history", ghist, 8'h00);

    // R1: one taken update on a fresh entry must flip it to predict taken (01 -> 10)
    step("R1", 9'd5, 9'd5, 4'h0, 1'b0, 1'b0, 8'h00);
    step("R1", 9'd5, 9'd5, 4'h0, 1'b1, 1'b1, 8'h00);
    step("R1", 9'd5, 9'd5, 4'h0, 1'b0, 1'b0, 8'h00);
    check("R1 counter trained", {7'd0, lk_taken}, 8'h01);

    // R7 / R10: same entry looked up and updated, drive into both limits
    for (int i = 0; i < 4; i++) step("R7 R10 up", 9'd5, 9'd5, 4'h0, 1'b1, 1'b1, 8'h00);
    step("R7 sat hi", 9'd5, 9'd5, 4'h0, 1'b1, 1'b0, 8'h00);
    step("R7 sat hi", 9'd5, 9'd5, 4'h0, 1'b0, 1'b0, 8'h00);
    for (int i = 0; i < 5; i++) step("R7 R10 down", 9'd5, 9'd5, 4'h0, 1'b1, 1'b0, 8'h00);
    step("R7 sat lo", 9'd5, 9'd5, 4'h0, 1'b1, 1'b1, 8'h00);
    step("R7 sat lo", 9'd5, 9'd5, 4'h0, 1'b0, 1'b0, 8'h00);

    // R11: invalid resolve with taken outcome touches nothing
    for (int i = 0; i < 3; i++) step("R11", 9'd9, 9'd9, 4'h0, 1'b0, 1'b1, 8'h00);

    // R6: address-only index, history non-zero
    step("R6", 9'd40, 9'd40, 4'h0, 1'b1, 1'b1, 8'hFF);
    step("R6", 9'd40, 9'd40, 4'h0, 1'b1, 1'b1, 8'h3C);
    step("R6", 9'd40, 9'd41, 4'h0, 1'b0, 1'b0, 8'h00);

    // R8: stale lookup-time history selects the counter
    step("R8", 9'd100, 9'd100, 4'h8, 1'b1, 1'b1, 8'hA5);
    step("R8", 9'd100, 9'd100, 4'h8, 1'b1, 1'b1, 8'hA5);
    step("R8", 9'd100 ^ 9'h0A5, 9'd0, 4'h8, 1'b0, 1'b0, 8'h00);

    // R4 / R5: each history length, with trained aliases
    for (int c = 0; c < 16; c++)
      for (int k = 0; k < 4; k++)
        step("R4 R5", 9'($urandom_range(0, 15)), 9'($urandom_range(0, 15)),
             4'(c), 1'b1, 1'($urandom_range(0, 1)), 8'($urandom));

    // R2 / R3 / R9 / R10: random mix from a small address pool
    for (int n = 0; n < 3000; n++) begin
      logic [8:0] lw, rw;
      logic [7:0] rh;
      lw = 9'($urandom_range(0, 31));
      rw = ($urandom_range(0, 3) == 0) ? lw : 9'($urandom_range(0, 31));
      rh = ($urandom_range(0, 1) == 1) ? mhist : 8'($urandom);
      step("R2 R3 R9", lw, rw, 4'($urandom_range(0, 15)),
           1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)), rh);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule